// File: doc/BRIEF.md
# Selectable-Source Baud Rate Divider

This block makes the baud-rate enable for a serial port. One 8-bit control register picks the clock source of a 5-bit counter and sets its division ratio. The source is one of eight: an external clock pin, the main clock itself, the main clock divided by 2, 4, 8, 16 or 32, or a pulse from a timer. The counter divides the selected source by 16 + k, where k is a 4-bit code from 0 to 14. Each time the count completes, `tick` goes high for one main-clock cycle.

Everything runs on the main clock. Prescaled sources come from a free-running prescaler as clock enables. The external pin passes through a synchroniser, and its rising edges become single-cycle enables. The timer pulse is taken as an enable that is already synchronous.

Register writes are refused while the serial link is busy, and a refused write raises an error flag. Code 15 is a prohibited divisor: it holds `tick` low and raises a flag until a legal code is written. Every accepted write restarts the count.

Top module: `baud_gen`

## Requirements
- R1: After reset the register reads 00h, and `tick`, `illegal_cfg` and `wr_err` are all low.
- R2: A write with `busy` low stores `wr_data[6:4]` as the source select (register bits 6:4) and `wr_data[3:0]` as the divisor code k (bits 3:0). It is visible on `ctrl_q` the next cycle. Bit 7 always reads 0.
- R3: A write with `busy` high leaves `ctrl_q` unchanged and sets `wr_err` the next cycle. `wr_err` stays high until the next accepted write clears it.
- R4: With select 001 (main clock), `tick` repeats every 16 + k cycles. The first `tick` is high 16 + k cycles after the clock edge that accepted the write.
- R5: With select 010, 011, 100, 101 or 110, the source is the main clock divided by 2, 4, 8, 16 or 32. Ticks are (16 + k) * 2^(select-1) cycles apart.
- R6: With select 000, each rising edge of `ext_clk` counts once after synchronisation. Ticks are (16 + k) times the pin period apart.
- R7: With select 111, each cycle with `timer_pulse` high counts once. Ticks are (16 + k) times the pulse spacing apart.
- R8: While k = 15, `illegal_cfg` is high and `tick` stays low. Writing a legal k clears the flag and restarts ticking.
- R9: `tick` is never high for two cycles in a row.
- R10: An accepted write in the middle of a count restarts it from zero. The next `tick` comes exactly 16 + k source enables later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 7 | Write data for register bits 6:0 |
| busy | input | 1 | Transfer in progress; blocks writes |
| ext_clk | input | 1 | Asynchronous external clock pin |
| timer_pulse | input | 1 | Synchronous single-cycle timer enable |
| ctrl_q | output | 8 | Current control register value |
| tick | output | 1 | One-cycle baud enable |
| illegal_cfg | output | 1 | Divisor code 15 is programmed |
| wr_err | output | 1 | Sticky refused-write flag |

## Verification
A counter stuck or loaded with the wrong limit shows up within one tick period as a gap between ticks that differs from (16 + k) times the source period. A wrong source-select decode changes the gap by a power of two, or by the pin or timer spacing. A missed reload on write moves the first tick away from exactly 16 + k enables after the write. A leaked busy write shows on `ctrl_q` one cycle later.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CTRL_W   = 8;
  localparam int SEL_W    = 3;
  localparam int DIV_W    = 4;
  localparam int CNT_W    = 5;
  localparam int BASE_DIV = 16;
  localparam int PRE_N    = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT   = 3'd0,
    SRC_MAIN  = 3'd1,
    SRC_D2    = 3'd2,
    SRC_D4    = 3'd3,
    SRC_D8    = 3'd4,
    SRC_D16   = 3'd5,
    SRC_D32   = 3'd6,
    SRC_TIMER = 3'd7
  } src_sel_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] en_o
);
  logic [STAGES-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // en_o[i] fires once every 2^(i+1) cycles
  for (genvar i = 0; i < STAGES; i++) begin : g_en
    assign en_o[i] = &cnt_q[i:0];
  end
endmodule

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[SYNC_STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // R6
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int CNT_W = 5,
  parameter int K_W   = 4,
  parameter int BASE  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reload_i,
  input  logic           src_en_i,
  input  logic           halt_i,
  input  logic [K_W-1:0] k_i,
  output logic           tick_o
);
  localparam int MAX_CNT = BASE + (1 << K_W) - 3;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             tick_q, tick_d;

  always_comb lim = CNT_W'(BASE - 1) + CNT_W'(k_i);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (reload_i) begin
      cnt_d = '0;
    end else if (src_en_i && !halt_i) begin
      if (cnt_q == lim) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R10
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == '0) && !tick_o);
  // R9
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_CNT);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-2:0] wr_data,
  input  logic              busy,
  input  logic              ext_clk,
  input  logic              timer_pulse,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              tick,
  output logic              illegal_cfg,
  output logic              wr_err
);
  logic [1:0] rst_sq;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  logic [CTRL_W-2:0] reg_q, reg_d;
  logic              err_q, err_d;
  logic              wr_ok;
  src_sel_e          sel;
  logic [DIV_W-1:0]  k;
  logic [PRE_N-1:0]  pre_en;
  logic              ext_rise, src_en;

  assign wr_ok = wr_en & ~busy;

  always_comb begin
    reg_d = reg_q;
    err_d = err_q;
    if (wr_ok) begin
      reg_d = wr_data;
      err_d = 1'b0;
    end else if (wr_en) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      err_q <= err_d;
    end
  end

  assign sel = src_sel_e'(reg_q[DIV_W +: SEL_W]);
  assign k   = reg_q[DIV_W-1:0];

  baud_prescaler #(.STAGES(PRE_N)) u_pre (
    .clk(clk), .rst_n(rst_ni), .en_o(pre_en)
  );

  baud_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_ni), .pin_i(ext_clk), .rise_o(ext_rise)
  );

  always_comb begin
    case (sel)
      SRC_EXT:   src_en = ext_rise;
      SRC_MAIN:  src_en = 1'b1;
      SRC_D2:    src_en = pre_en[0];
      SRC_D4:    src_en = pre_en[1];
      SRC_D8:    src_en = pre_en[2];
      SRC_D16:   src_en = pre_en[3];
      SRC_D32:   src_en = pre_en[4];
      default:   src_en = timer_pulse;
    endcase
  end

  assign illegal_cfg = &k;

  baud_div_counter #(.CNT_W(CNT_W), .K_W(DIV_W), .BASE(BASE_DIV)) u_div (
    .clk(clk), .rst_n(rst_ni), .reload_i(wr_ok), .src_en_i(src_en),
    .halt_i(illegal_cfg), .k_i(k), .tick_o(tick)
  );

  assign ctrl_q = {1'b0, reg_q};
  assign wr_err = err_q;

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && busy) |=> ($stable(ctrl_q) && wr_err));
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    illegal_cfg |-> !tick);
  // R2
  msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_ok |=> !ctrl_q[CTRL_W-1] && !wr_err);
endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic       busy = 1'b0;
  logic       ext_clk = 1'b0;
  logic       timer_pulse = 1'b0;
  logic [7:0] ctrl_q;
  logic       tick, illegal_cfg, wr_err;

  int total = 0, fails = 0;
  int cyc = 0;
  int wcyc = 0;
  int ext_half = 0, ext_ph = 0;
  int tmr_gap = 0, tmr_ph = 0;

  baud_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .ext_clk(ext_clk), .timer_pulse(timer_pulse), .ctrl_q(ctrl_q),
    .tick(tick), .illegal_cfg(illegal_cfg), .wr_err(wr_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : ext_drv
    forever begin
      @(negedge clk);
      if (ext_half > 0) begin
        ext_ph++;
        if (ext_ph >= ext_half) begin ext_clk = ~ext_clk; ext_ph = 0; end
      end
    end
  end

  initial begin : tmr_drv
    forever begin
      @(negedge clk);
      if (tmr_gap > 0) begin
        tmr_ph++;
        timer_pulse = (tmr_ph >= tmr_gap);
        if (tmr_ph >= tmr_gap) tmr_ph = 0;
      end else timer_pulse = 1'b0;
    end
  end

  function automatic int div_of(input int kk);
    return 16 + kk;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [3:0] kk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {s, kk};
    @(posedge clk); #1;
    wcyc = cyc;
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(output int at);
    at = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tick) begin at = cyc; break; end
    end
  endtask

  task automatic measure(input int exp, input string req);
    int t1, t2;
    wait_tick(t1);
    wait_tick(t2);
    check(t1 >= 0 && t2 >= 0 && (t2 - t1) == exp, req, t2 - t1, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin : main
    int t, nt, kk, p, seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);
    check(!tick && !illegal_cfg && !wr_err, "R1 flags",
          {tick, illegal_cfg, wr_err}, 0);

    // R2 write and readback, bit 7 zero
    write_reg(3'b101, 4'd9);
    @(negedge clk);
    check(ctrl_q == 8'h59, "R2 readback", ctrl_q, 8'h59);

    // R3 busy write refused
    busy = 1'b1;
    write_reg(3'b010, 4'd3);
    busy = 1'b0;
    @(negedge clk);
    check(ctrl_q == 8'h59, "R3 ctrl unchanged", ctrl_q, 8'h59);
    check(wr_err == 1'b1, "R3 err set", wr_err, 1);
    write_reg(3'b001, 4'd0);
    @(negedge clk);
    check(wr_err == 1'b0, "R3 err cleared", wr_err, 0);

    // R4 first tick latency and period, k=0 and k=14
    write_reg(3'b001, 4'd0);
    wait_tick(t);
    check(t - wcyc == 16, "R4 first tick k0", t - wcyc, 16);
    measure(16, "R4 period k0");
    write_reg(3'b001, 4'd14);
    wait_tick(t);
    check(t - wcyc == 30, "R4 first tick k14", t - wcyc, 30);
    measure(30, "R4 period k14");

    // R9 tick width
    wait_tick(t);
    @(negedge clk);
    check(!tick, "R9 one cycle", tick, 0);

    // R10 reload mid-count
    write_reg(3'b001, 4'd5);
    wait_tick(t);
    repeat (7) @(negedge clk);
    write_reg(3'b001, 4'd5);
    wait_tick(t);
    check(t - wcyc == 21, "R10 reload restart", t - wcyc, 21);

    // R8 prohibited code
    write_reg(3'b001, 4'd15);
    @(negedge clk);
    check(illegal_cfg == 1'b1, "R8 flag", illegal_cfg, 1);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R8 tick held", seen, 0);
    write_reg(3'b001, 4'd2);
    @(negedge clk);
    check(illegal_cfg == 1'b0, "R8 flag cleared", illegal_cfg, 0);
    wait_tick(t);
    check(t - wcyc == 18, "R8 resume", t - wcyc, 18);

    // R5 prescaled sources, directed extremes then random
    write_reg(3'b110, 4'd14);
    measure(30 * 32, "R5 div32 k14");
    write_reg(3'b010, 4'd0);
    measure(16 * 2, "R5 div2 k0");
    for (int n = 0; n < 10; n++) begin
      kk = $urandom_range(14, 0);
      p  = $urandom_range(6, 2);
      write_reg(3'(p), 4'(kk));
      measure(div_of(kk) * (1 << (p - 1)), "R5 random prescale");
    end

    // R6 external pin
    ext_half = 3;
    write_reg(3'b000, 4'd4);
    measure(20 * 6, "R6 ext period 6");
    ext_half = 5;
    kk = $urandom_range(14, 0);
    write_reg(3'b000, 4'(kk));
    measure(div_of(kk) * 10, "R6 ext period 10");
    ext_half = 0;

    // R7 timer pulse
    tmr_gap = 3;
    write_reg(3'b111, 4'd1);
    measure(17 * 3, "R7 timer gap 3");
    tmr_gap = 7;
    kk = $urandom_range(14, 0);
    write_reg(3'b111, 4'(kk));
    measure(div_of(kk) * 7, "R7 timer gap 7");
    tmr_gap = 0;
    write_reg(3'b111, 4'd0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R7 no pulses no tick", seen, 0);
    nt = seen;

    summary();
    $finish;
  end
endmodule